// File: doc/BRIEF.md
# Serial-Write Control Register Bank

This block is a write-only configuration port. A host drives three wires: a frame enable, a serial clock and serial data. While the enable is high, each rising edge of the serial clock captures one data bit. A complete write is sixteen bits long: a seven-bit register address, one spare bit, then eight data bits. The block keeps twelve 8-bit control registers and presents each one as a parallel output. These registers hold power-down, filter cutoff and boost, two pulse thresholds, two control words, two synthesizer counters, VCO centering, window shift and write precompensation.

Nothing is written while bits are arriving. A write happens only when the enable falls, and only if exactly sixteen clock edges were seen in that enable window. If a seventeenth edge arrives, the frame is void. A frame that is too short, or that names an address the bank does not decode, changes nothing. The three serial inputs are asynchronous to the block clock, so they are synchronized and then edge-detected in the block clock domain.

Top module: `scfg_port`

## Requirements
- R1: When `rst_n` is low, every register output reads zero, including when `rst_n` is asserted in the middle of operation.
- R2: A frame is sent LSB first. It carries seven address bits, then one spare bit whose value is ignored, then eight data bits. Each bit is sampled on a rising edge of `ser_clk` while `ser_en` is high. The address map is: power down 0x02, cutoff 0x03, boost 0x0B, data threshold 0x0A, servo threshold 0x12, control A 0x1A, counter N 0x06, counter M 0x0E, VCO center 0x04, window shift 0x05, precomp 0x0D, control B 0x0C.
- R3: A complete frame changes no output while `ser_en` stays high. The frame is committed only after `ser_en` falls.
- R4: If a seventeenth `ser_clk` rising edge arrives in one enable window, the frame is void and no register changes.
- R5: If `ser_en` falls after fewer than sixteen edges, no register changes.
- R6: A frame whose full seven-bit address is not in the map changes no register.
- R7: Bits that are not used are stored as zero, whatever data is written. The stored bits are: cutoff, boost, counter N and VCO center keep bits 6:0; control A keeps bits 6:0; window shift keeps bits 5:0 (magnitude in 3:0, direction in 4, enable in 5); precomp keeps bits 3:0. The power-down, both threshold, counter M and control B registers keep all eight bits.
- R8: `ser_clk` edges while `ser_en` is low shift nothing and do not disturb the next frame.
- R9: Frames sent one after another each update their own register and leave the others as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Frame enable, high while a frame is shifted |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| pwr_dn | output | 8 | Power-down register |
| flt_cut | output | 8 | Filter cutoff register |
| flt_boost | output | 8 | Filter boost register |
| thr_data | output | 8 | Data-mode pulse threshold |
| thr_servo | output | 8 | Servo-mode pulse threshold |
| ctl_a | output | 8 | Control word A |
| syn_n | output | 8 | Synthesizer counter N |
| syn_m | output | 8 | Synthesizer counter M |
| vco_ctr | output | 8 | VCO center register |
| win_shift | output | 8 | Window shift magnitude, direction and enable |
| wr_precomp | output | 8 | Write precompensation |
| ctl_b | output | 8 | Control word B |

## Verification
The assertions take for granted that each serial input holds steady for several block clocks between changes. They also assume data is stable around every `ser_clk` rise and that `ser_clk` is low whenever `ser_en` changes. Under those conditions the synchronized samples reproduce the host's edges one for one. The bench therefore holds each serial level for four block clocks. It lowers the clock before it raises or drops the enable, and it waits ten block clocks after every enable fall before it reads any output.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int AW    = 7;
  localparam int DW    = 8;
  localparam int FRAME = AW + 1 + DW;
  localparam int NREG  = 12;
  localparam int CW    = $clog2(FRAME + 2);

  localparam int IX_PD = 0, IX_CUT = 1, IX_BST = 2, IX_THD = 3, IX_THS = 4, IX_CA = 5;
  localparam int IX_SN = 6, IX_SM = 7, IX_VCO = 8, IX_WIN = 9, IX_PRE = 10, IX_CB = 11;

  localparam logic [AW-1:0] REG_ADDR [NREG] = '{
    7'h02, 7'h03, 7'h0B, 7'h0A, 7'h12, 7'h1A,
    7'h06, 7'h0E, 7'h04, 7'h05, 7'h0D, 7'h0C};

  localparam logic [DW-1:0] REG_MASK [NREG] = '{
    8'hFF, 8'h7F, 8'h7F, 8'hFF, 8'hFF, 8'h7F,
    8'h7F, 8'hFF, 8'h7F, 8'h3F, 8'h0F, 8'hFF};
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[0], d_async[i]};
    end
    assign q[i] = stg[1];
  end
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter
  import scfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_s,
  input  logic          sclk_s,
  input  logic          dat_s,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME);
  localparam logic [CW-1:0] CNT_VOID = CW'(FRAME + 1);

  logic             en_q, sclk_q;
  logic [FRAME-1:0] sr, sr_nxt;
  logic [CW-1:0]    cnt_nxt;
  logic             stb_nxt, sclk_rise, en_fall;

  assign sclk_rise = en_s & sclk_s & ~sclk_q;
  assign en_fall   = en_q & ~en_s;

  always_comb begin
    cnt_nxt = bit_cnt;
    sr_nxt  = sr;
    if (!en_s) begin
      cnt_nxt = '0;
    end else if (sclk_rise && bit_cnt != CNT_VOID) begin
      cnt_nxt = bit_cnt + 1'b1;
      if (bit_cnt < CNT_FULL) sr_nxt = {dat_s, sr[FRAME-1:1]};
    end
    stb_nxt = en_fall && (bit_cnt == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      sr      <= '0;
      wr_stb  <= 1'b0;
    end else begin
      en_q    <= en_s;
      sclk_q  <= sclk_s;
      bit_cnt <= cnt_nxt;
      sr      <= sr_nxt;
      wr_stb  <= stb_nxt;
    end
  end

  assign wr_addr = sr[AW-1:0];
  assign wr_data = sr[FRAME-1:AW+1];
endmodule

// File: rtl/scfg_regfile.sv
module scfg_regfile
  import scfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG-1:0]    sel,
  output logic [NREG*DW-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] val, val_nxt;
    assign sel[i] = wr_stb && (wr_addr == REG_ADDR[i]);
    always_comb begin
      val_nxt = val;
      if (sel[i]) val_nxt = wr_data & REG_MASK[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else        val <= val_nxt;
    end
    assign regs_flat[i*DW +: DW] = val;
  end
endmodule

// File: rtl/scfg_port.sv
module scfg_port
  import scfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en,
  input  logic          ser_clk,
  input  logic          ser_dat,
  output logic [DW-1:0] pwr_dn,
  output logic [DW-1:0] flt_cut,
  output logic [DW-1:0] flt_boost,
  output logic [DW-1:0] thr_data,
  output logic [DW-1:0] thr_servo,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] syn_n,
  output logic [DW-1:0] syn_m,
  output logic [DW-1:0] vco_ctr,
  output logic [DW-1:0] win_shift,
  output logic [DW-1:0] wr_precomp,
  output logic [DW-1:0] ctl_b
);
  logic [1:0]         rst_stg;
  logic               rst_n_int;
  logic [2:0]         sync_q;
  logic               en_s, sclk_s, dat_s;
  logic               wr_stb;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      wr_data;
  logic [CW-1:0]      bit_cnt;
  logic [NREG-1:0]    sel;
  logic [NREG*DW-1:0] regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_stg <= '0;
    else        rst_stg <= {rst_stg[0], 1'b1};
  end
  assign rst_n_int = rst_stg[1];

  scfg_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d_async({ser_dat, ser_clk, ser_en}), .q(sync_q));
  assign {dat_s, sclk_s, en_s} = sync_q;

  scfg_shifter u_shift (
    .clk(clk), .rst_n(rst_n_int), .en_s(en_s), .sclk_s(sclk_s), .dat_s(dat_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .bit_cnt(bit_cnt));

  scfg_regfile u_rf (
    .clk(clk), .rst_n(rst_n_int), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel(sel), .regs_flat(regs_flat));

  assign pwr_dn     = regs_flat[IX_PD*DW  +: DW];
  assign flt_cut    = regs_flat[IX_CUT*DW +: DW];
  assign flt_boost  = regs_flat[IX_BST*DW +: DW];
  assign thr_data   = regs_flat[IX_THD*DW +: DW];
  assign thr_servo  = regs_flat[IX_THS*DW +: DW];
  assign ctl_a      = regs_flat[IX_CA*DW  +: DW];
  assign syn_n      = regs_flat[IX_SN*DW  +: DW];
  assign syn_m      = regs_flat[IX_SM*DW  +: DW];
  assign vco_ctr    = regs_flat[IX_VCO*DW +: DW];
  assign win_shift  = regs_flat[IX_WIN*DW +: DW];
  assign wr_precomp = regs_flat[IX_PRE*DW +: DW];
  assign ctl_b      = regs_flat[IX_CB*DW  +: DW];
endmodule

// File: rtl/scfg_port_chk.sv
module scfg_port_chk
  import scfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               en_s,
  input logic               wr_stb,
  input logic [CW-1:0]      bit_cnt,
  input logic [NREG-1:0]    sel,
  input logic [NREG*DW-1:0] regs_flat
);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FRAME + 1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_flat));

  p_commit_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !en_s);

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> bit_cnt == '0);

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[IX_CA*DW + 7] == 1'b0 && regs_flat[IX_PRE*DW + 4 +: 4] == 4'h0 &&
    regs_flat[IX_WIN*DW + 6 +: 2] == 2'b00 && regs_flat[IX_CUT*DW + 7] == 1'b0);
endmodule

bind scfg_port scfg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n_int), .en_s(en_s), .wr_stb(wr_stb),
  .bit_cnt(bit_cnt), .sel(sel), .regs_flat(regs_flat));

// File: tb/scfg_port_bench.sv
module scfg_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [7:0] o [12];
  logic [7:0] exp_v [12];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Address and mask per register, taken from R2 and R7
  localparam logic [6:0] A [12] = '{7'h02, 7'h03, 7'h0B, 7'h0A, 7'h12, 7'h1A,
                                    7'h06, 7'h0E, 7'h04, 7'h05, 7'h0D, 7'h0C};
  localparam logic [7:0] M [12] = '{8'hFF, 8'h7F, 8'h7F, 8'hFF, 8'hFF, 8'h7F,
                                    8'h7F, 8'hFF, 8'h7F, 8'h3F, 8'h0F, 8'hFF};

  always #10 clk = ~clk;

  scfg_port u_scfg_port (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .pwr_dn(o[0]), .flt_cut(o[1]), .flt_boost(o[2]), .thr_data(o[3]), .thr_servo(o[4]),
    .ctl_a(o[5]), .syn_n(o[6]), .syn_m(o[7]), .vco_ctr(o[8]), .win_shift(o[9]),
    .wr_precomp(o[10]), .ctl_b(o[11]));

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] expv, int idx);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s reg %0d actual %02h expected %02h", req, idx, act, expv);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 12; i++) check(req, o[i], exp_v[i], i);
  endtask

  task automatic send_bit(logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  // Send nbits of {data, spare, addr}, LSB first, then drop enable
  task automatic frame(logic [6:0] addr, logic [7:0] data, logic spare, int nbits);
    logic [15:0] w;
    w = {data, spare, addr};
    ser_en = 1'b1;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) send_bit(i < 16 ? w[i] : 1'b1);
    wait_clk(4);
    ser_en = 1'b0;
    wait_clk(10);
  endtask

  task automatic write_ok(int idx, logic [7:0] data);
    frame(A[idx], data, 1'b0, 16);
    exp_v[idx] = data & M[idx];
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) exp_v[i] = 8'h00;
    check_all("R1 reset");
  endtask

  task automatic t_all_regs;
    for (int i = 0; i < 12; i++) write_ok(i, 8'hFF);
    check_all("R7 all-ones masked");
    for (int i = 0; i < 12; i++) write_ok(i, 8'h5A ^ 8'(i * 37));
    check_all("R2 pattern per address");
  endtask

  task automatic t_spare_bit;
    frame(A[3], 8'hC3, 1'b1, 16);
    exp_v[3] = 8'hC3;
    check("R2 spare bit ignored", o[3], exp_v[3], 3);
  endtask

  task automatic t_hold_until_fall;
    logic [15:0] w;
    w = {8'h96, 1'b0, A[7]};
    ser_en = 1'b1;
    wait_clk(4);
    for (int i = 0; i < 16; i++) send_bit(w[i]);
    wait_clk(12);
    check("R3 held while enable high", o[7], exp_v[7], 7);
    ser_en = 1'b0;
    wait_clk(10);
    exp_v[7] = 8'h96;
    check("R3 commit on fall", o[7], exp_v[7], 7);
  endtask

  task automatic t_overflow;
    frame(A[11], 8'h3C, 1'b0, 17);
    check_all("R4 seventeenth edge voids");
  endtask

  task automatic t_short;
    frame(A[0], 8'hE7, 1'b0, 15);
    check_all("R5 short frame");
  endtask

  task automatic t_bad_addr;
    frame(7'h01, 8'h11, 1'b0, 16);
    frame(7'h42, 8'h22, 1'b0, 16);
    frame(7'h7F, 8'h33, 1'b0, 16);
    check_all("R6 undefined address");
  endtask

  task automatic t_idle_clocks;
    ser_en = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    write_ok(4, 8'h81);
    check_all("R8 idle edges ignored");
  endtask

  task automatic t_back_to_back;
    write_ok(9, 8'hF5);
    write_ok(10, 8'hA6);
    write_ok(5, 8'h80);
    check_all("R9 consecutive frames");
    check("R7 control A bit 7", o[5], 8'h00, 5);
  endtask

  task automatic t_async_reset;
    wait_clk(2);
    #3 rst_n = 1'b0;
    #5;
    for (int i = 0; i < 12; i++) exp_v[i] = 8'h00;
    check_all("R1 mid-run reset");
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_all_regs();
    t_spare_bit();
    t_hold_until_fall();
    t_overflow();
    t_short();
    t_bad_addr();
    t_idle_clocks();
    t_back_to_back();
    t_async_reset();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule